// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block resolves the control flow of a 32-bit RISC core where every branch and jump has one delay slot. On each clock it takes the current program counter, a control-transfer kind, two register operands, a 16-bit word offset, a 26-bit jump index and a destination register number. One cycle later it presents the next program counter, a taken flag, a link value, a link-enable flag and the register number the link is written to.

Conditional branches compare the two operands for equality or inequality, or test the first operand as a signed number against zero. PC-relative targets are based on the delay-slot address PC+4. Absolute jumps keep the upper four bits of the current PC and append the index scaled to bytes. Register jumps use the first operand as the target. Link forms write PC+8, the address just past the delay slot, and the conditional link forms write it whether the branch is taken or not.

Top module: `branch_next_pc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next edge-registered outputs become `next_pc_o` = RESET_PC (default 0xBFC00000), with `taken_o`, `link_en_o`, `link_val_o` and `link_reg_o` all zero. Out of reset every output reflects the inputs sampled at the previous rising edge.
- R2: Kind 0 (sequential) and the unused codes 13 to 15 give `next_pc_o` = PC+4, `taken_o` = 0 and no link.
- R3: A conditional branch whose condition is false gives `next_pc_o` = PC+4 and `taken_o` = 0.
- R4: Conditional kinds are 1 equal (A==B), 2 not equal (A!=B), 3 A>=0, 4 A>0, 5 A<=0, 6 A<0, 7 A>=0 with link, 8 A<0 with link, the zero tests treating A as signed. When true, `taken_o` = 1 and `next_pc_o` = PC+4 + (sign-extended offset << 2).
- R5: Kind 9 (jump) and 10 (jump with link) always take, with `next_pc_o` = {PC[31:28], index, 2'b00}.
- R6: Kind 11 (register jump) and 12 (register jump with link) always take, with `next_pc_o` equal to operand A unchanged.
- R7: Kinds 7, 8 and 10 set `link_en_o`, `link_reg_o` = 31 and `link_val_o` = PC+8, for kinds 7 and 8 also when not taken; kind 12 does the same with `link_reg_o` equal to the destination input.
- R8: Every kind without link gives `link_en_o` = 0, `link_val_o` = 0 and `link_reg_o` = 0.
- R9: All address sums wrap modulo 2^32, and the region bits of an absolute jump come from PC itself, not from PC+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_i | input | 32 | Address of the branch or jump |
| kind_i | input | 4 | Control-transfer kind, codes per R2, R4 to R7 |
| opa_i | input | 32 | First register operand, also register-jump target |
| opb_i | input | 32 | Second register operand |
| offset_i | input | 16 | Signed word offset for PC-relative branches |
| index_i | input | 26 | Word index for absolute jumps |
| link_dst_i | input | 5 | Link destination for register jump with link |
| next_pc_o | output | 32 | Next program counter |
| taken_o | output | 1 | Control transfer taken |
| link_val_o | output | 32 | Return address to write |
| link_en_o | output | 1 | Link write enable |
| link_reg_o | output | 5 | Register number receiving the link |

## Verification
The link write and the branch decision fall in the same cycle for the conditional link kinds, and the link must appear regardless of the outcome. The bench drives kinds 7 and 8 with operands of both signs, including zero and the most negative value, so each form is seen both taken and not taken, and a behavioural model compares target, taken flag and all link outputs on every clock. Wrap at the top of the address space and a jump whose PC+4 crosses a region boundary are driven as directed cases.

// File: rtl/branch_next_pc.sv
module branch_next_pc #(
  parameter logic [31:0] RESET_PC = 32'hBFC0_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pc_i,
  input  logic [3:0]  kind_i,
  input  logic [31:0] opa_i,
  input  logic [31:0] opb_i,
  input  logic [15:0] offset_i,
  input  logic [25:0] index_i,
  input  logic [4:0]  link_dst_i,
  output logic [31:0] next_pc_o,
  output logic        taken_o,
  output logic [31:0] link_val_o,
  output logic        link_en_o,
  output logic [4:0]  link_reg_o
);
  localparam logic [3:0] K_SEQ = 4'd0, K_EQ = 4'd1, K_NE = 4'd2, K_GEZ = 4'd3,
                         K_GTZ = 4'd4, K_LEZ = 4'd5, K_LTZ = 4'd6, K_GEZL = 4'd7,
                         K_LTZL = 4'd8, K_J = 4'd9, K_JL = 4'd10, K_JR = 4'd11,
                         K_JRL = 4'd12;
  localparam logic [4:0] RA = 5'd31;

  logic [31:0] slot_pc, ret_pc, rel_tgt, abs_tgt;
  logic        same, neg, zero;

  assign slot_pc = pc_i + 32'd4;
  assign ret_pc  = pc_i + 32'd8;
  assign rel_tgt = slot_pc + {{14{offset_i[15]}}, offset_i, 2'b00};
  assign abs_tgt = {pc_i[31:28], index_i, 2'b00};
  assign same    = (opa_i == opb_i);
  assign neg     = opa_i[31];
  assign zero    = (opa_i == 32'd0);

  logic        take, lnk;
  logic [31:0] tgt;
  logic [4:0]  lreg;

  always_comb begin
    take = 1'b0;
    tgt  = rel_tgt;
    lnk  = 1'b0;
    lreg = RA;
    case (kind_i)
      K_EQ:   take = same;
      K_NE:   take = !same;
      K_GEZ:  take = !neg;
      K_GTZ:  take = !neg && !zero;
      K_LEZ:  take = neg || zero;
      K_LTZ:  take = neg;
      K_GEZL: begin take = !neg; lnk = 1'b1; end
      K_LTZL: begin take = neg;  lnk = 1'b1; end
      K_J:    begin take = 1'b1; tgt = abs_tgt; end
      K_JL:   begin take = 1'b1; tgt = abs_tgt; lnk = 1'b1; end
      K_JR:   begin take = 1'b1; tgt = opa_i; end
      K_JRL:  begin take = 1'b1; tgt = opa_i; lnk = 1'b1; lreg = link_dst_i; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o  <= RESET_PC;
      taken_o    <= 1'b0;
      link_val_o <= '0;
      link_en_o  <= 1'b0;
      link_reg_o <= '0;
    end else begin
      next_pc_o  <= take ? tgt : slot_pc;
      taken_o    <= take;
      link_en_o  <= lnk;
      link_val_o <= lnk ? ret_pc : 32'd0;
      link_reg_o <= lnk ? lreg : 5'd0;
    end
  end

  a_r3_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !taken_o |-> next_pc_o == $past(pc_i) + 32'd4);

  a_r7_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    link_en_o |-> link_val_o == $past(pc_i) + 32'd8);

  a_r8_quiet_link: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en_o |-> (link_val_o == 32'd0 && link_reg_o == 5'd0));

  a_r5_region_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(kind_i) == K_J || $past(kind_i) == K_JL)
      |-> taken_o && next_pc_o[31:28] == $past(pc_i[31:28]));

  a_r7_cond_link_always: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(kind_i) == K_GEZL || $past(kind_i) == K_LTZL)
      |-> link_en_o && link_reg_o == RA);

  a_r6_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && ($past(kind_i) == K_JR || $past(kind_i) == K_JRL)
      |-> taken_o && next_pc_o == $past(opa_i));
endmodule

// File: tb/test_branch_next_pc.sv
module test_branch_next_pc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic [3:0]  kind_i = '0;
  logic [15:0] offset_i = '0;
  logic [25:0] index_i = '0;
  logic [4:0]  link_dst_i = '0;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_en_o;
  logic [4:0]  link_reg_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  branch_next_pc i_branch_next_pc (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] k, input logic [31:0] pc,
      input logic [31:0] a, input logic [31:0] b, input logic [15:0] off,
      input logic [25:0] idx, input logic [4:0] dst,
      output logic [31:0] npc, output bit tk, output bit le,
      output logic [31:0] lv, output logic [4:0] lr, output string tag);
    longint sa = $signed(a);
    longint so = $signed(off);
    bit cond = 0;
    bit isbr = 1;
    le = 0; lr = 0; lv = 0;
    case (k)
      1: cond = (a == b);
      2: cond = (a != b);
      3, 7: cond = (sa >= 0);
      4: cond = (sa > 0);
      5: cond = (sa <= 0);
      6, 8: cond = (sa < 0);
      default: isbr = 0;
    endcase
    if (k == 7 || k == 8 || k == 10) begin le = 1; lr = 31; end
    if (k == 12) begin le = 1; lr = dst; end
    if (le) lv = 32'((longint'(pc) + 8) % 64'h1_0000_0000);
    if (isbr) begin
      tk = cond;
      npc = cond ? 32'(longint'(pc) + 4 + so * 4) : 32'(longint'(pc) + 4);
      tag = cond ? "R4" : "R3";
    end else if (k == 9 || k == 10) begin
      tk = 1; npc = (pc & 32'hF000_0000) | (32'(idx) * 4); tag = "R5";
    end else if (k == 11 || k == 12) begin
      tk = 1; npc = a; tag = "R6";
    end else begin
      tk = 0; npc = 32'(longint'(pc) + 4); tag = "R2";
    end
  endfunction

  task automatic step(input logic [3:0] k, input logic [31:0] pc, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] off, input logic [25:0] idx,
                      input logic [4:0] dst, input string extra);
    logic [31:0] npc, lv;
    logic [4:0] lr;
    bit tk, le;
    string tag;
    @(negedge clk);
    kind_i = k; pc_i = pc; opa_i = a; opb_i = b; offset_i = off; index_i = idx; link_dst_i = dst;
    model(k, pc, a, b, off, idx, dst, npc, tk, le, lv, lr, tag);
    @(posedge clk); #1;
    if (extra != "") tag = {tag, "/", extra};
    chk(next_pc_o == npc, tag, "next_pc", next_pc_o, npc);
    chk(taken_o == tk, tag, "taken", taken_o, tk);
    chk(link_en_o == le && link_val_o == lv && link_reg_o == lr, le ? "R7" : "R8",
        "link", {link_en_o, link_reg_o, link_val_o}, {le, lr, lv});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(next_pc_o == 32'hBFC0_0000, "R1", "reset pc", next_pc_o, 32'hBFC0_0000);
    chk(!taken_o && !link_en_o && link_val_o == 0 && link_reg_o == 0, "R1", "reset flags",
        {taken_o, link_en_o, link_reg_o, link_val_o}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(0, 32'h0000_1000, 0, 0, 0, 0, 0, "R2");
    step(14, 32'h0000_1000, 5, 5, 16'h0010, 0, 0, "R2");
    step(1, 32'h0040_0100, 7, 7, 16'hFFFF, 0, 0, "");
    step(1, 32'h0040_0100, 7, 8, 16'hFFFF, 0, 0, "");
    step(2, 32'h0040_0100, 7, 8, 16'h7FFF, 0, 0, "");
    step(4, 32'h0040_0100, 0, 0, 16'h0003, 0, 0, "");
    step(5, 32'h0040_0100, 0, 0, 16'h8000, 0, 0, "");
    step(3, 32'h0040_0100, 32'h8000_0000, 0, 16'h0003, 0, 0, "");
    step(6, 32'h0040_0100, 32'h8000_0000, 0, 16'h0003, 0, 0, "");
    step(7, 32'h0040_0200, 32'h8000_0000, 0, 16'h0004, 0, 0, "R7 not taken");
    step(7, 32'h0040_0200, 0, 0, 16'h0004, 0, 0, "R7 taken");
    step(8, 32'h0040_0200, 1, 0, 16'hFFF0, 0, 0, "R7 not taken");
    step(8, 32'h0040_0200, 32'hFFFF_FFFF, 0, 16'hFFF0, 0, 0, "R7 taken");
    step(9, 32'h2FFF_FFFC, 0, 0, 0, 26'h3FF_FFFF, 0, "R9 region");
    step(10, 32'h7000_0040, 0, 0, 0, 26'h000_1234, 0, "");
    step(11, 32'h0000_0800, 32'h1234_5677, 0, 0, 0, 0, "");
    step(12, 32'h0000_0800, 32'hABCD_0000, 0, 0, 0, 5'd9, "");
    step(0, 32'hFFFF_FFFC, 0, 0, 0, 0, 0, "R9 wrap");
    step(12, 32'hFFFF_FFF8, 32'h10, 0, 0, 0, 5'd4, "R9 wrap");
    step(1, 32'hFFFF_FFF0, 3, 3, 16'h0010, 0, 0, "R9 wrap");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = ($urandom % 3 == 0) ? a : $urandom;
      if ($urandom % 5 == 0) a = 0;
      step(4'($urandom), $urandom, a, b, 16'($urandom), 26'($urandom), 5'($urandom), "");
    end
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk(next_pc_o == 32'hBFC0_0000 && !link_en_o && !taken_o, "R1", "re-reset",
        next_pc_o, 32'hBFC0_0000);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule